// File: doc/BRIEF.md
# Receive Frame Writer With Status Header

This block takes received Ethernet frames one byte at a time and lays them into the upper receive area of a 16 KiB byte-wide packet memory. The area runs from 0x0C00 to 0x3FFF. The lower part of the memory belongs to the transmit side and is not written by this block, with one exception covered in R4. A frame is announced by its first byte, which carries the frame length on a side bus.

The block first checks that the receive area still has room for a frame. It then writes a four-byte status header just below its current write pointer. Next it stores the frame bytes, then writes a run of zero bytes: runt padding, four placeholder bytes for the checksum, and a cleared next header. Finally it moves the pointer on, wrapping it inside the receive area and leaving it on an even address.

A host-side reader owns the read pointer. That pointer comes in as an input and is used only for the free-space check. A sticky receive interrupt bit reports each stored frame.

Top module: `rx_frame_writer`

## Requirements
- R1: After reset the write pointer is 0x0C04, the interrupt bit is 0, `in_ready` is 0 and no memory write is issued.
- R2: Free space is computed from the write pointer `w` and the read pointer `r`:
  - if `w < r`, free space is `r - w`;
  - otherwise it is `13312 - (w - r)`.

  A frame no longer than 2048 bytes is started only while free space is above 2048. `space_ok` shows that condition. While it is false, a frame start is held off with `in_ready` at 0, and nothing is written.
- R3: A frame whose announced length is above 2048 is consumed byte by byte with `in_ready` at 1. It causes no memory write, no pointer change and no interrupt.
- R4: Before any frame byte is taken, four header bytes are written on four consecutive cycles with `in_ready` at 0. They go to addresses write pointer −4 through −1, with no wrap applied. The values are, in order:
  - 0x01;
  - 0x00;
  - the low byte of the stored length;
  - the high byte of the stored length.
- R5: The stored length is the frame length plus 4. A frame shorter than 64 bytes is stored with length 68.
- R6: Frame bytes are written at the write pointer and at the addresses that follow, one per accepted byte. They are followed by (stored length + 4 − frame length) zero bytes. The total number of writes per frame is 4 + frame length + that zero count.
- R7: After every stored byte the pointer advances by one. A value of 16384 or more has 16384 subtracted from it, and a value below 0x0C00 then has 0x0C00 added. As a result, 0x3FFF is followed by 0x0C00.
- R8: After the last zero byte, the pointer is first rounded up to an even value and then wrapped as in R7.
- R9: The interrupt bit goes to 1 on the clock edge that writes the last zero byte of a frame. It stays at 1 until `irq_clr` is pulsed. If a set and a clear fall on the same edge, the set wins.
- R10: A frame starts only when `in_valid` and `in_first` are both high while the block is idle. Any other input while idle changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A frame byte is offered |
| in_first | input | 1 | The offered byte is the first of a frame |
| in_len | input | LEN_W (16) | Frame length in bytes, valid with the first byte |
| in_data | input | 8 | Frame byte |
| in_ready | output | 1 | The offered byte is taken at the next edge |
| rd_ptr | input | AW (14) | Host read pointer into the receive area |
| space_ok | output | 1 | Free space exceeds the largest frame |
| mem_we | output | 1 | Byte write strobe to the packet memory |
| mem_addr | output | AW (14) | Byte address of the write |
| mem_wdata | output | 8 | Byte written |
| wr_ptr | output | AW (14) | Current receive write pointer |
| irq_clr | input | 1 | Clears the receive interrupt bit |
| rx_irq | output | 1 | Receive interrupt status bit |

## Verification
The sequence starts with the idle edge that samples the first byte. The four header writes fall on the next four edges, and `in_ready` rises in the cycle after the last of them. Each frame byte is written on the edge that accepts it. The zero run takes exactly as many edges as the zero count, and the final one of these edges updates both the pointer and the interrupt bit. The bench samples only on falling edges. It waits out a fixed margin that is longer than the longest zero run, then compares memory contents, pointer and interrupt. The blocked-start and ignored-input checks hold their stimulus for ten cycles before reading the ports.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_DATA,
        ST_PAD,
        ST_DROP
    } rxw_state_e;

endpackage

// File: rtl/rxw_space.sv
module rxw_space #(
    parameter int AW      = 14,
    parameter int BASE    = 'h0C00,
    parameter int MAX_LEN = 2048
) (
    input  logic [AW-1:0] wr_i,
    input  logic [AW-1:0] rd_i,
    output logic          ok_o
);
    localparam int SW = AW + 2;
    localparam logic [SW-1:0] REGION = SW'((1 << AW) - BASE);

    logic [SW-1:0] free_bytes;

    always_comb begin
        if (wr_i < rd_i) begin
            free_bytes = SW'(rd_i) - SW'(wr_i);
        end else begin
            free_bytes = REGION - (SW'(wr_i) - SW'(rd_i));
        end
        ok_o = (free_bytes > SW'(MAX_LEN));
    end

endmodule

// File: rtl/rxw_ptr_step.sv
module rxw_ptr_step #(
    parameter int AW   = 14,
    parameter int BASE = 'h0C00
) (
    input  logic [AW-1:0] ptr_i,
    input  logic          last_i,
    output logic [AW-1:0] ptr_o
);
    localparam logic [AW:0] TOP = (AW+1)'(1 << AW);

    logic [AW:0] inc;
    logic [AW:0] wrapped;

    always_comb begin
        inc = {1'b0, ptr_i} + (AW+1)'(1);
        if (last_i) begin
            inc = (inc + (AW+1)'(1)) & ~(AW+1)'(1);
        end
        wrapped = (inc >= TOP) ? (inc - TOP) : inc;
        if (wrapped < (AW+1)'(BASE)) begin
            wrapped = wrapped + (AW+1)'(BASE);
        end
        ptr_o = wrapped[AW-1:0];
    end

endmodule

// File: rtl/rx_frame_writer.sv
module rx_frame_writer
    import rxw_pkg::*;
#(
    parameter int AW      = 14,
    parameter int RX_BASE = 'h0C00,
    parameter int RST_PTR = 'h0C04,
    parameter int MAX_LEN = 2048,
    parameter int MIN_LEN = 64,
    parameter int LEN_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_first,
    input  logic [LEN_W-1:0] in_len,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    input  logic [AW-1:0]    rd_ptr,
    output logic             space_ok,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [7:0]       mem_wdata,
    output logic [AW-1:0]    wr_ptr,
    input  logic             irq_clr,
    output logic             rx_irq
);
    localparam int TAIL  = 8;
    localparam int ZW    = $clog2(MIN_LEN + TAIL + 1);
    localparam int HDR_N = 4;

    typedef struct packed {
        rxw_state_e       state;
        logic [AW-1:0]    ptr;
        logic [LEN_W-1:0] cnt;
        logic [ZW-1:0]    zcnt;
        logic [1:0]       hidx;
        logic [LEN_W-1:0] stored;
        logic             irq;
    } regs_t;

    regs_t q, d;

    logic          pad_last;
    logic [AW-1:0] ptr_nxt;
    rxw_state_e    cur_state;

    assign cur_state = q.state;
    assign pad_last  = (q.state == ST_PAD) && (q.zcnt == ZW'(1));

    rxw_space #(.AW(AW), .BASE(RX_BASE), .MAX_LEN(MAX_LEN)) u_space (
        .wr_i (q.ptr),
        .rd_i (rd_ptr),
        .ok_o (space_ok)
    );

    rxw_ptr_step #(.AW(AW), .BASE(RX_BASE)) u_step (
        .ptr_i  (q.ptr),
        .last_i (pad_last),
        .ptr_o  (ptr_nxt)
    );

    always_comb begin
        d         = q;
        in_ready  = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = q.ptr;
        mem_wdata = 8'h00;

        if (irq_clr) begin
            d.irq = 1'b0;
        end

        case (q.state)
            ST_IDLE: begin
                if (in_valid && in_first) begin
                    if (in_len > LEN_W'(MAX_LEN)) begin
                        d.state = ST_DROP;
                        d.cnt   = in_len;
                    end else if (space_ok) begin
                        d.state = ST_HDR;
                        d.hidx  = 2'd0;
                        d.cnt   = in_len;
                        if (in_len < LEN_W'(MIN_LEN)) begin
                            d.stored = LEN_W'(MIN_LEN + 4);
                            d.zcnt   = ZW'(LEN_W'(MIN_LEN + TAIL) - in_len);
                        end else begin
                            d.stored = in_len + LEN_W'(4);
                            d.zcnt   = ZW'(TAIL);
                        end
                    end
                end
            end

            ST_HDR: begin
                mem_we   = 1'b1;
                mem_addr = q.ptr - AW'(HDR_N) + AW'(q.hidx);
                case (q.hidx)
                    2'd0:    mem_wdata = 8'h01;
                    2'd1:    mem_wdata = 8'h00;
                    2'd2:    mem_wdata = q.stored[7:0];
                    default: mem_wdata = q.stored[15:8];
                endcase
                d.hidx = q.hidx + 2'd1;
                if (q.hidx == 2'd3) begin
                    d.state = (q.cnt == '0) ? ST_PAD : ST_DATA;
                end
            end

            ST_DATA: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    mem_we    = 1'b1;
                    mem_addr  = q.ptr;
                    mem_wdata = in_data;
                    d.ptr     = ptr_nxt;
                    d.cnt     = q.cnt - LEN_W'(1);
                    if (q.cnt == LEN_W'(1)) begin
                        d.state = ST_PAD;
                    end
                end
            end

            ST_PAD: begin
                mem_we    = 1'b1;
                mem_addr  = q.ptr;
                mem_wdata = 8'h00;
                d.ptr     = ptr_nxt;
                d.zcnt    = q.zcnt - ZW'(1);
                if (pad_last) begin
                    d.state = ST_IDLE;
                    d.irq   = 1'b1;
                end
            end

            ST_DROP: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    d.cnt = q.cnt - LEN_W'(1);
                    if (q.cnt == LEN_W'(1)) begin
                        d.state = ST_IDLE;
                    end
                end
            end

            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, ptr: AW'(RST_PTR), default: '0};
        end else begin
            q <= d;
        end
    end

    assign wr_ptr = q.ptr;
    assign rx_irq = q.irq;

endmodule

// File: rtl/rx_frame_writer_chk.sv
module rx_frame_writer_chk
    import rxw_pkg::*;
#(
    parameter int AW      = 14,
    parameter int RX_BASE = 'h0C00,
    parameter int MAX_LEN = 2048,
    parameter int LEN_W   = 16
) (
    input logic             clk,
    input logic             rst_n,
    input rxw_state_e       cur_state,
    input logic [AW-1:0]    wr_ptr,
    input logic             mem_we,
    input logic             in_valid,
    input logic             in_first,
    input logic [LEN_W-1:0] in_len,
    input logic             space_ok,
    input logic             rx_irq
);

    assert_ptr_in_region_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ptr >= AW'(RX_BASE));

    assert_even_at_rest_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_IDLE) |-> !wr_ptr[0]);

    assert_drop_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_DROP) |-> !mem_we);

    assert_no_start_when_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_IDLE && in_valid && in_first &&
         in_len <= LEN_W'(MAX_LEN) && !space_ok) |=> (cur_state == ST_IDLE));

    assert_irq_from_pad_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_irq) |-> ($past(cur_state) == ST_PAD));

    assert_idle_ptr_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_IDLE && $past(cur_state) == ST_IDLE) |-> $stable(wr_ptr));

endmodule

bind rx_frame_writer rx_frame_writer_chk #(
    .AW(AW), .RX_BASE(RX_BASE), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cur_state (cur_state),
    .wr_ptr    (wr_ptr),
    .mem_we    (mem_we),
    .in_valid  (in_valid),
    .in_first  (in_first),
    .in_len    (in_len),
    .space_ok  (space_ok),
    .rx_irq    (rx_irq)
);

// File: tb/rx_frame_writer_test.sv
module rx_frame_writer_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_first = 1'b0;
    logic [15:0]   in_len = '0;
    logic [7:0]    in_data = '0;
    logic          in_ready;
    logic [AW-1:0] rd_ptr = 14'h0C04;
    logic          space_ok;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic [AW-1:0] wr_ptr;
    logic          irq_clr = 1'b0;
    logic          rx_irq;

    int tests = 0;
    int fails = 0;
    int nwr = 0;
    logic [7:0] mem [int];

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_frame_writer uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
        .in_len(in_len), .in_data(in_data), .in_ready(in_ready), .rd_ptr(rd_ptr),
        .space_ok(space_ok), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .wr_ptr(wr_ptr), .irq_clr(irq_clr), .rx_irq(rx_irq)
    );

    always @(posedge clk) begin
        if (mem_we) begin
            mem[int'(mem_addr)] = mem_wdata;
            nwr = nwr + 1;
        end
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
        end
    endtask

    function automatic int step(input int p, input bit last);
        int n = p + 1;
        if (last) n = (n + 1) & ~1;
        if (n >= 16384) n = n - 16384;
        if (n < 'h0C00) n = n + 'h0C00;
        return n;
    endfunction

    function automatic logic [7:0] datab(input int seed, input int i);
        return 8'((seed + i * 7 + 1) & 255);
    endfunction

    function automatic int rd(input int a);
        if (mem.exists(a)) return int'(mem[a]);
        return -1;
    endfunction

    task automatic push_frame(input int len, input int seed);
        for (int i = 0; i < len; i++) begin
            in_valid = 1'b1;
            in_first = (i == 0);
            in_len   = 16'(len);
            in_data  = datab(seed, i);
            while (!in_ready) @(negedge clk);
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_first = 1'b0;
        repeat (80) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic test_reset();
        do_reset();
        chk(wr_ptr == 14'h0C04, "R1 reset pointer", int'(wr_ptr), 'h0C04);
        chk(rx_irq == 1'b0, "R1 reset irq", int'(rx_irq), 0);
        chk(in_ready == 1'b0, "R1 reset ready", int'(in_ready), 0);
        chk(mem_we == 1'b0, "R1 reset write strobe", int'(mem_we), 0);
    endtask

    task automatic test_idle_ignore();
        int n0 = nwr;
        int p0 = int'(wr_ptr);
        in_valid = 1'b1; in_first = 1'b0; in_len = 16'd20; in_data = 8'h55;
        repeat (10) @(negedge clk);
        chk(in_ready == 1'b0, "R10 ready stays low without first", int'(in_ready), 0);
        chk(nwr == n0, "R10 no writes without first", nwr - n0, 0);
        chk(int'(wr_ptr) == p0, "R10 pointer unchanged", int'(wr_ptr), p0);
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_frame(input int len, input int seed);
        int base   = int'(wr_ptr);
        int n0     = nwr;
        int stored = (len < 64) ? 68 : len + 4;
        int zeros  = stored + 4 - len;
        int p      = base;
        bit ok     = 1'b1;
        rd_ptr = wr_ptr;
        push_frame(len, seed);
        chk(rd(base - 4) == 1, "R4 header ready byte", rd(base - 4), 1);
        chk(rd(base - 3) == 0, "R4 header status byte", rd(base - 3), 0);
        chk(rd(base - 2) == (stored & 255), "R5 stored length low", rd(base - 2), stored & 255);
        chk(rd(base - 1) == (stored >> 8), "R5 stored length high", rd(base - 1), stored >> 8);
        for (int i = 0; i < len; i++) begin
            if (rd(p) != int'(datab(seed, i))) ok = 1'b0;
            p = step(p, 1'b0);
        end
        chk(ok, "R6 frame bytes in place", len, len);
        ok = 1'b1;
        for (int i = 0; i < zeros; i++) begin
            if (rd(p) != 0) ok = 1'b0;
            p = step(p, i == zeros - 1);
        end
        chk(ok, "R6 trailing zero bytes", zeros, zeros);
        chk(int'(wr_ptr) == p, "R7 R8 final pointer", int'(wr_ptr), p);
        chk(nwr - n0 == 4 + len + zeros, "R6 write count", nwr - n0, 4 + len + zeros);
        chk(rx_irq == 1'b1, "R9 irq set on store", int'(rx_irq), 1);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        chk(rx_irq == 1'b0, "R9 irq cleared", int'(rx_irq), 0);
    endtask

    task automatic test_drop();
        int n0 = nwr;
        int p0 = int'(wr_ptr);
        rd_ptr = wr_ptr;
        push_frame(2049, 3);
        chk(nwr == n0, "R3 oversize frame writes nothing", nwr - n0, 0);
        chk(int'(wr_ptr) == p0, "R3 oversize keeps pointer", int'(wr_ptr), p0);
        chk(rx_irq == 1'b0, "R3 oversize raises no irq", int'(rx_irq), 0);
    endtask

    task automatic test_blocked();
        int n0 = nwr;
        int p0 = int'(wr_ptr);
        rd_ptr = AW'(p0 + 2048);
        @(negedge clk);
        chk(space_ok == 1'b0, "R2 space of exactly 2048 refused", int'(space_ok), 0);
        in_valid = 1'b1; in_first = 1'b1; in_len = 16'd40; in_data = 8'hA5;
        repeat (10) @(negedge clk);
        chk(in_ready == 1'b0, "R2 start held off", int'(in_ready), 0);
        chk(nwr == n0, "R2 no header while full", nwr - n0, 0);
        chk(int'(wr_ptr) == p0, "R2 pointer kept while full", int'(wr_ptr), p0);
        in_valid = 1'b0; in_first = 1'b0;
        rd_ptr = AW'(p0 + 2049);
        @(negedge clk);
        chk(space_ok == 1'b1, "R2 space of 2049 accepted", int'(space_ok), 1);
    endtask

    task automatic test_wrap();
        bit wrapped = 1'b0;
        for (int k = 0; k < 9 && !wrapped; k++) begin
            int old = int'(wr_ptr);
            run_frame(2047, 40 + k);
            if (int'(wr_ptr) < old) wrapped = 1'b1;
        end
        chk(wrapped, "R7 pointer wrapped into receive area", int'(wrapped), 1);
        run_frame(17, 99);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual 0x0 expected 0x1");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        test_reset();
        test_idle_ignore();
        run_frame(10, 1);
        run_frame(101, 2);
        run_frame(64, 5);
        run_frame(63, 6);
        test_drop();
        test_blocked();
        run_frame(2048, 7);
        test_wrap();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule